// File: doc/BRIEF.md
# Register-Mapped Watchdog Timer

A watchdog peripheral on a simple 32-bit register bus. A down-counter is reloaded with one of sixteen power-of-two cycle counts, 2^(BASE_EXP+n) - 1, where n comes from a 4-bit period field. Software keeps the system alive by writing one magic word to a kick register. Any other value written there is ignored. The enable bit can only be set. Once the timer is running, only a hardware reset stops it.

When the counter expires, the block responds in one of two ways, chosen by a response-mode bit. In reset mode it drives an 8-cycle system reset pulse. In interrupt mode it raises an interrupt and reloads. If that interrupt is still pending at the next expiry, the block drives the reset pulse. A separate start-period field sets the length of the first period after enable. Every later reload uses the main period field. BASE_EXP defaults to 16 and may be lowered to shorten simulation.

Register offsets: 0x00 control, 0x04 period, 0x08 live count (read only), 0x0C kick (write only), 0x10 interrupt status (read-to-clear). Read data appears on `rdata_o` in the cycle after `re_i`.

Top module: `guard_timer`

## Requirements
- R1: After reset, control and period registers read 0, `irq_o` and `sys_rst_o` are low, and reads of unmapped offsets return 0.
- R2: While control bit 0 (enable) is 0, the count register reads 2^(BASE_EXP+s)-1, where s is period-register bits [7:4]. A kick write has no effect, and both outputs stay low.
- R3: Writing 1 to control bit 0 sets the enable bit, and writing 0 afterwards leaves it set. Control bit 1 (response mode) reads back as written.
- R4: The first expiry after enable happens 2^(BASE_EXP+s) clock edges after the edge that captures the enable write, with s = period bits [7:4].
- R5: Writing 32'h76 to offset 0x0C loads 2^(BASE_EXP+p)-1, where p is period bits [3:0]. The next expiry comes 2^(BASE_EXP+p) edges after that write, and every reload after an expiry also uses p.
- R6: Writing any other value to offset 0x0C leaves the countdown untouched.
- R7: With control bit 1 = 0, an expiry drives `sys_rst_o` high for exactly 8 cycles and leaves `irq_o` low.
- R8: With control bit 1 = 1, an expiry with no interrupt pending sets `irq_o` and reloads without a reset. An expiry while `irq_o` is set drives the reset pulse.
- R9: Reading offset 0x10 returns the pending interrupt in bit 0 and clears it. A valid kick write also clears it.
- R10: Reading offset 0x08 returns the live count, which falls by one per clock while enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after `re_i` |
| irq_o | output | 1 | Pending expiry interrupt |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The bench measures exact edge counts to each expiry:
- The first period after enable must use the start field, not the main field. A design that reused the main field would expire 16 edges early or late.
- Kicks must reload from the main field. A design with an off-by-one reload would miss the power-of-two distances across the scan of period values.
- A near-miss kick word must not restart the counter. A design that accepted it would push the expiry back.

In interrupt mode, the interrupt is cleared once by a read and then left pending. A design that never escalated, or escalated on the first expiry, would show the reset pulse at the wrong time. The bench also tries to clear the enable bit. The reset pulse width is measured and must be exactly 8 cycles.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;
  localparam int unsigned OFF_CTRL  = 32'h00;
  localparam int unsigned OFF_RANGE = 32'h04;
  localparam int unsigned OFF_COUNT = 32'h08;
  localparam int unsigned OFF_KICK  = 32'h0C;
  localparam int unsigned OFF_IRQ   = 32'h10;
  localparam logic [31:0] KICK_WORD = 32'h0000_0076;
  localparam int unsigned SEL_W     = 4;
  localparam int unsigned N_PERIODS = 1 << SEL_W;

  typedef struct packed {
    logic mode;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/guard_timer_regs.sv
module guard_timer_regs
  import guard_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              irq_pend_i,
  output logic [DATA_W-1:0] rdata_o,
  output ctrl_t             ctrl_o,
  output logic [SEL_W-1:0]  top_o,
  output logic [SEL_W-1:0]  init_o,
  output logic              kick_o,
  output logic              irq_clr_o
);
  logic sel_ctrl, sel_range, sel_count, sel_kick, sel_irq;
  ctrl_t ctrl_q;
  logic [SEL_W-1:0] top_q, init_q;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  assign sel_ctrl  = addr_i == ADDR_W'(OFF_CTRL);
  assign sel_range = addr_i == ADDR_W'(OFF_RANGE);
  assign sel_count = addr_i == ADDR_W'(OFF_COUNT);
  assign sel_kick  = addr_i == ADDR_W'(OFF_KICK);
  assign sel_irq   = addr_i == ADDR_W'(OFF_IRQ);

  assign kick_o    = we_i && sel_kick && (wdata_i == DATA_W'(KICK_WORD));
  assign irq_clr_o = (re_i && sel_irq) || kick_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      top_q  <= '0;
      init_q <= '0;
    end else if (we_i) begin
      if (sel_ctrl) begin
        ctrl_q.en   <= ctrl_q.en | wdata_i[0];  // set-only
        ctrl_q.mode <= wdata_i[1];
      end
      if (sel_range) begin
        top_q  <= wdata_i[SEL_W-1:0];
        init_q <= wdata_i[2*SEL_W-1:SEL_W];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_ctrl)  rd_mux = DATA_W'(ctrl_q);
    if (sel_range) rd_mux = DATA_W'({init_q, top_q});
    if (sel_count) rd_mux = DATA_W'(cnt_i);
    if (sel_irq)   rd_mux = DATA_W'(irq_pend_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign ctrl_o  = ctrl_q;
  assign top_o   = top_q;
  assign init_o  = init_q;
endmodule

// File: rtl/guard_timer_counter.sv
module guard_timer_counter
  import guard_timer_pkg::*;
#(
  parameter int unsigned BASE_EXP = 16,
  parameter int unsigned CNT_W    = BASE_EXP + N_PERIODS - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             kick_i,
  input  logic [SEL_W-1:0] top_i,
  input  logic [SEL_W-1:0] init_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] RST_VAL = CNT_W'((64'd1 << BASE_EXP) - 64'd1);

  logic [CNT_W-1:0] reload_tbl [N_PERIODS];
  logic [CNT_W-1:0] cnt_q;

  for (genvar g = 0; g < N_PERIODS; g++) begin : g_reload
    localparam logic [CNT_W:0] ONE_SH = (CNT_W+1)'(1) << (BASE_EXP + g);
    assign reload_tbl[g] = ONE_SH[CNT_W-1:0] - CNT_W'(1);
  end

  assign expire_o = en_i && !kick_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= RST_VAL;
    else if (!en_i)                  cnt_q <= reload_tbl[init_i];
    else if (kick_i || cnt_q == '0)  cnt_q <= reload_tbl[top_i];
    else                             cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/guard_timer_resp.sv
module guard_timer_resp #(
  parameter int unsigned RST_PULSE = 8,
  localparam int unsigned PW = $clog2(RST_PULSE + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic mode_i,
  input  logic irq_clr_i,
  output logic irq_o,
  output logic sys_rst_o
);
  logic          irq_q;
  logic [PW-1:0] pulse_q;
  logic          fire_rst;

  // reset mode always resets; interrupt mode escalates on an unserviced irq
  assign fire_rst = expire_i && (!mode_i || irq_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q   <= 1'b0;
      pulse_q <= '0;
    end else begin
      if (expire_i && mode_i && !irq_q) irq_q <= 1'b1;
      else if (irq_clr_i)               irq_q <= 1'b0;
      if (fire_rst)           pulse_q <= PW'(RST_PULSE);
      else if (pulse_q != '0) pulse_q <= pulse_q - PW'(1);
    end
  end

  assign irq_o     = irq_q;
  assign sys_rst_o = pulse_q != '0;
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_timer_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned BASE_EXP  = 16,
  parameter int unsigned RST_PULSE = 8,
  localparam int unsigned DATA_W   = 32,
  localparam int unsigned CNT_W    = BASE_EXP + N_PERIODS - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              sys_rst_o
);
  ctrl_t            ctrl;
  logic [SEL_W-1:0] top_q, init_q;
  logic             kick, irq_clr, expire, irq_pend, en_q;
  logic [CNT_W-1:0] cnt_q;

  assign en_q = ctrl.en;

  guard_timer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_regs (
    .clk_i, .rst_ni, .we_i, .re_i, .addr_i, .wdata_i,
    .cnt_i(cnt_q), .irq_pend_i(irq_pend), .rdata_o,
    .ctrl_o(ctrl), .top_o(top_q), .init_o(init_q),
    .kick_o(kick), .irq_clr_o(irq_clr)
  );

  guard_timer_counter #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) i_cnt (
    .clk_i, .rst_ni, .en_i(en_q), .kick_i(kick),
    .top_i(top_q), .init_i(init_q), .cnt_o(cnt_q), .expire_o(expire)
  );

  guard_timer_resp #(.RST_PULSE(RST_PULSE)) i_resp (
    .clk_i, .rst_ni, .expire_i(expire), .mode_i(ctrl.mode),
    .irq_clr_i(irq_clr), .irq_o(irq_pend), .sys_rst_o
  );

  assign irq_o = irq_pend;
endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk
  import guard_timer_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned BASE_EXP  = 16,
  parameter int unsigned RST_PULSE = 8,
  parameter int unsigned CNT_W     = BASE_EXP + N_PERIODS - 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              irq_o,
  input logic              sys_rst_o,
  input logic              en_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [SEL_W-1:0]  top_q
);
  function automatic logic [CNT_W-1:0] full_len(input logic [SEL_W-1:0] n);
    logic [CNT_W:0] s;
    s = (CNT_W+1)'(1) << (BASE_EXP + 32'(n));
    return s[CNT_W-1:0] - CNT_W'(1);
  endfunction

  logic kick_wr, odd_wr;
  logic [7:0] run_len;

  assign kick_wr = we_i && addr_i == ADDR_W'(OFF_KICK) && wdata_i == KICK_WORD;
  assign odd_wr  = we_i && addr_i == ADDR_W'(OFF_KICK) && wdata_i != KICK_WORD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_len <= '0;
    else if (sys_rst_o) run_len <= run_len + 8'd1;
    else                run_len <= '0;
  end

  assert_quiet_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (!irq_o && !sys_rst_o));
  assert_en_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q);
  assert_kick_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_wr && en_q) |=> cnt_q == full_len($past(top_q)));
  assert_odd_word_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (odd_wr && en_q && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  assert_pulse_max_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> run_len < 8'(RST_PULSE));
  assert_pulse_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> run_len == 8'(RST_PULSE));
  assert_kick_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_wr && en_q) |=> !irq_o);
  assert_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && cnt_q != '0 && !kick_wr) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
endmodule

bind guard_timer guard_timer_chk #(
  .ADDR_W(ADDR_W), .BASE_EXP(BASE_EXP), .RST_PULSE(RST_PULSE), .CNT_W(CNT_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .irq_o(irq_o), .sys_rst_o(sys_rst_o),
  .en_q(en_q), .cnt_q(cnt_q), .top_q(top_q)
);

// File: tb/test_guard_timer.sv
module test_guard_timer;
  localparam int B = 4;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0, re = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, srst;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  guard_timer #(.ADDR_W(AW), .BASE_EXP(B)) i_guard_timer (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .sys_rst_o(srst)
  );

  typedef struct packed {
    logic        we;
    logic        re;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic        chk;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 8'h00, 32'h0,  1'b1, 32'h0,  8'd1},   // R1 ctrl
    '{1'b0, 1'b1, 8'h04, 32'h0,  1'b1, 32'h0,  8'd1},   // R1 period
    '{1'b0, 1'b1, 8'h08, 32'h0,  1'b1, 32'd15, 8'd2},   // R2 count
    '{1'b1, 1'b0, 8'h04, 32'h21, 1'b0, 32'h0,  8'd4},
    '{1'b0, 1'b0, 8'h00, 32'h0,  1'b0, 32'h0,  8'd4},
    '{1'b0, 1'b1, 8'h04, 32'h0,  1'b1, 32'h21, 8'd4},   // R4 fields
    '{1'b0, 1'b1, 8'h08, 32'h0,  1'b1, 32'd63, 8'd2},   // R2 start len
    '{1'b1, 1'b0, 8'h00, 32'h2,  1'b0, 32'h0,  8'd3},
    '{1'b0, 1'b1, 8'h00, 32'h0,  1'b1, 32'h2,  8'd3},   // R3 mode
    '{1'b1, 1'b0, 8'h0C, 32'h76, 1'b0, 32'h0,  8'd2},
    '{1'b0, 1'b1, 8'h08, 32'h0,  1'b1, 32'd63, 8'd2},   // R2 kick ignored
    '{1'b0, 1'b1, 8'h10, 32'h0,  1'b1, 32'h0,  8'd9},   // R9
    '{1'b0, 1'b1, 8'h14, 32'h0,  1'b1, 32'h0,  8'd1},   // R1 unmapped
    '{1'b1, 1'b0, 8'h00, 32'h0,  1'b0, 32'h0,  8'd3}
  };

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; we = 1'b0; re = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    we = 1'b1; addr = a[AW-1:0]; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    re = 1'b1; addr = a[AW-1:0];
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  // edges until the chosen output is high (0: sys_rst, 1: irq)
  task automatic wait_for(input bit which, input int limit, output int k);
    k = 0;
    while (((which ? irq : srst) == 1'b0) && k < limit) begin
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, r1, r2;
    int k, n, bad;

    do_reset();
    check("R1", "irq after reset", irq, 0);
    check("R1", "sys_rst after reset", srst, 0);

    for (int i = 0; i < NV; i++) begin
      we = VECS[i].we; re = VECS[i].re;
      addr = VECS[i].addr[AW-1:0]; wdata = VECS[i].wdata;
      @(negedge clk);
      we = 1'b0; re = 1'b0;
      if (VECS[i].chk) begin
        checks++;
        if (rdata !== VECS[i].exp) begin
          errors++;
          $display("FAIL R%0d vector %0d actual=%0h expected=%0h",
                   VECS[i].req, i, rdata, VECS[i].exp);
        end
      end
    end
    check("R2", "outputs quiet during table", {irq, srst}, 0);

    // R2: disabled timer stays quiet
    do_reset();
    bad = 0;
    repeat (300) begin
      @(negedge clk);
      if (irq || srst) bad++;
    end
    check("R2", "disabled outputs", bad, 0);

    // R4, R7, R3: start period, pulse width, sticky enable
    do_reset();
    bus_write(8'h04, 32'h10);
    bus_write(8'h00, 32'h1);
    wait_for(0, 200, k);
    check("R4", "first expiry edges", k, 1 << (B + 1));
    check("R7", "irq in reset mode", irq, 0);
    n = 0;
    while (srst && n < 50) begin
      @(negedge clk);
      n++;
    end
    check("R7", "pulse width", n, 8);
    wait_for(0, 200, k);
    check("R5", "later reload uses main field", k, (1 << B) - 8);
    bus_write(8'h00, 32'h0);
    bus_read(8'h00, v);
    check("R3", "enable sticky", v[0], 1);

    // R6, R10, R5: odd word, live count, kick
    do_reset();
    bus_write(8'h04, 32'h02);
    bus_write(8'h00, 32'h1);
    bus_write(8'h0C, 32'h77);
    wait_for(0, 200, k);
    check("R6", "odd kick word ignored", k, (1 << B) - 1);
    while (srst) @(negedge clk);
    bus_read(8'h08, r1);
    repeat (4) @(negedge clk);
    bus_read(8'h08, r2);
    check("R10", "count falls per clock", r1 - r2, 5);
    bus_write(8'h0C, 32'h76);
    bus_read(8'h08, v);
    check("R5", "count after kick", v, (1 << (B + 2)) - 1);
    wait_for(0, 200, k);
    check("R5", "expiry after kick", k, (1 << (B + 2)) - 1);

    // R5: scan of main period values
    for (int p = 0; p < 9; p++) begin
      while (srst) @(negedge clk);
      bus_write(8'h04, 32'(p));
      bus_write(8'h0C, 32'h76);
      wait_for(0, (1 << (B + p)) + 20, k);
      check("R5", $sformatf("period scan p=%0d", p), k, 1 << (B + p));
    end

    // R8, R9: interrupt mode and escalation
    do_reset();
    bus_write(8'h00, 32'h3);
    wait_for(1, 200, k);
    check("R8", "irq first expiry", k, 1 << B);
    check("R8", "no reset on first expiry", srst, 0);
    bus_read(8'h10, v);
    check("R9", "status read value", v, 1);
    check("R9", "irq cleared by read", irq, 0);
    wait_for(1, 200, k);
    check("R8", "irq second expiry", k, (1 << B) - 1);
    wait_for(0, 200, k);
    check("R8", "escalation to reset", k, 1 << B);
    check("R8", "irq held at escalation", irq, 1);
    while (srst) @(negedge clk);
    bus_write(8'h0C, 32'h76);
    check("R9", "irq cleared by kick", irq, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule